// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is a legacy configuration port on an 8-bit I/O bus, built from two byte addresses: an index address and a data address one above it. A strap input picks which of two index addresses the port answers on (0x2E when low, 0x4E when high). After reset the port is locked. To unlock it, a host writes a four-byte key to the index address. Once the port is unlocked, a byte written to the index address selects a register. The data address then reads or writes the selected register.

A global register selects the logical device number, and a second global register selects the input clock rate. A small fixed set of logical devices each own a bank with an activate bit, two 16-bit base addresses and an interrupt select byte. All of these settings leave the block as parallel outputs, which the surrounding chip uses to place and enable its peripherals. Writing the exit code to the control register locks the port again.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked. Every `dev_en`, `dev_base0`, `dev_base1` and `dev_irq` bit is 0, `clk_sel_24m` is 0, and a read at the index or data address returns 0xFF.
- R2: The index address is 0x2E when `strap_alt`=0 and 0x4E when `strap_alt`=1. The data address is the index address plus one. The port unlocks only after the bytes 0x87, 0x01, 0x55 and then K are written in order to the index address. K is 0x55 when `strap_alt`=0 and 0xAA when `strap_alt`=1. Writes to any other address have no effect.
- R3: A key byte that does not match resets the key matching. If that byte is 0x87, it counts as the first byte of a new attempt.
- R4: While the port is locked, writes to the data address change no register and no output, and reads of the data address return 0xFF.
- R5: While the port is unlocked, writing 0x02 to register 0x02 locks the port. Writing any other value to register 0x02 has no effect. Register 0x02 reads as 0x00.
- R6: Register 0x07 holds the logical device number (LDN). It can be read and written, and it selects which device bank the per-device registers address.
- R7: Per-device register 0x30 bit 0 is the activate bit. It drives that device's `dev_en` bit and reads back as {7'b0, bit}.
- R8: Per-device registers 0x60/0x61 hold base address 0 (high byte, then low byte), 0x62/0x63 hold base address 1, and 0x70 holds the interrupt select. Each one drives its output field and reads back the value written.
- R9: The implemented LDNs are 0x00, 0x01, 0x04, 0x05, 0x06, 0x07 and 0x0A. They map in that order to output slots 0 to 6 (slot i occupies `dev_base0[16*i+:16]`, `dev_irq[8*i+:8]`). For any other LDN, per-device registers read 0xFF and ignore writes.
- R10: Register 0x23 bit 0 selects the 24 MHz input clock. It resets to 0, drives `clk_sel_24m` and reads back as {7'b0, bit}.
- R11: While the port is unlocked, a read at the index address returns the current index. Unmapped registers read 0x00. A read at any address other than the port's two addresses returns 0x00, and `io_rdata` is 0x00 whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Selects index address 0x4E (1) or 0x2E (0) |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| dev_en | output | 7 | Activate bit per device slot |
| dev_base0 | output | 112 | Base address 0 per slot, 16 bits each |
| dev_base1 | output | 112 | Base address 1 per slot, 16 bits each |
| dev_irq | output | 56 | Interrupt select per slot, 8 bits each |
| clk_sel_24m | output | 1 | Input clock select, 1 = 24 MHz |

## Verification
The hardest states to reach are the partial-key states: a wrong byte lands in the middle of the key, or a 0x87 restarts the match after one or two correct bytes, and the last key byte must match the strap. Directed sequences interleave 0x87 bytes and give the wrong last byte for each strap setting. Random traffic then mixes whole keys, keys with one corrupted byte, writes of the exit code and accesses at the other strap's address. A bench model tracks the key progress and predicts every read and output.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    KS_IDLE,
    KS_GOT1,
    KS_GOT2,
    KS_GOT3,
    KS_OPEN
  } key_state_e;

  localparam logic [BYTE_W-1:0] KEY_B0 = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_B1 = 8'h01;
  localparam logic [BYTE_W-1:0] KEY_B2 = 8'h55;

  localparam logic [BYTE_W-1:0] RG_CTRL = 8'h02;
  localparam logic [BYTE_W-1:0] RG_LDN  = 8'h07;
  localparam logic [BYTE_W-1:0] RG_CLK  = 8'h23;
  localparam logic [BYTE_W-1:0] RG_ACT  = 8'h30;
  localparam logic [BYTE_W-1:0] RG_B0H  = 8'h60;
  localparam logic [BYTE_W-1:0] RG_B0L  = 8'h61;
  localparam logic [BYTE_W-1:0] RG_B1H  = 8'h62;
  localparam logic [BYTE_W-1:0] RG_B1L  = 8'h63;
  localparam logic [BYTE_W-1:0] RG_IRQ  = 8'h70;

  localparam logic [BYTE_W-1:0] EXIT_CODE = 8'h02;

  function automatic logic is_dev_reg(input logic [BYTE_W-1:0] r);
    return (r == RG_ACT) || (r == RG_B0H) || (r == RG_B0L) ||
           (r == RG_B1H) || (r == RG_B1L) || (r == RG_IRQ);
  endfunction

endpackage

// File: rtl/sio_key_unlock.sv
module sio_key_unlock
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic [BYTE_W-1:0] last_byte,
  input  logic              relock,
  output logic              unlocked
);

  key_state_e st_q, st_d;
  key_state_e restart;

  // A mismatching byte may itself open a new attempt
  assign restart = (key_byte == KEY_B0) ? KS_GOT1 : KS_IDLE;

  always_comb begin
    st_d = st_q;
    case (st_q)
      KS_IDLE: if (key_wr) st_d = restart;
      KS_GOT1: if (key_wr) st_d = (key_byte == KEY_B1) ? KS_GOT2 : restart;
      KS_GOT2: if (key_wr) st_d = (key_byte == KEY_B2) ? KS_GOT3 : restart;
      KS_GOT3: if (key_wr) st_d = (key_byte == last_byte) ? KS_OPEN : restart;
      KS_OPEN: if (relock) st_d = KS_IDLE;
      default: st_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == KS_OPEN);

  // Opening only follows a write of the final key byte
  assert_unlock_on_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && (key_byte == last_byte)));

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   idx,
  input  logic [BYTE_W-1:0]   wdata,
  output logic                en,
  output logic [2*BYTE_W-1:0] base0,
  output logic [2*BYTE_W-1:0] base1,
  output logic [BYTE_W-1:0]   irq,
  output logic [BYTE_W-1:0]   rd_data
);

  localparam int BASE_W = 2 * BYTE_W;

  logic              we;
  logic              en_q, en_d;
  logic [BASE_W-1:0] b0_q, b0_d, b1_q, b1_d;
  logic [BYTE_W-1:0] irq_q, irq_d;
  logic [BYTE_W-1:0] rd_val;

  assign we = wr_en & sel;

  always_comb begin
    en_d  = en_q;
    b0_d  = b0_q;
    b1_d  = b1_q;
    irq_d = irq_q;
    case (idx)
      RG_ACT: en_d  = wdata[0];
      RG_B0H: b0_d  = {wdata, b0_q[BYTE_W-1:0]};
      RG_B0L: b0_d  = {b0_q[BASE_W-1:BYTE_W], wdata};
      RG_B1H: b1_d  = {wdata, b1_q[BYTE_W-1:0]};
      RG_B1L: b1_d  = {b1_q[BASE_W-1:BYTE_W], wdata};
      RG_IRQ: irq_d = wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      b0_q  <= '0;
      b1_q  <= '0;
      irq_q <= '0;
    end else if (we) begin
      en_q  <= en_d;
      b0_q  <= b0_d;
      b1_q  <= b1_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    case (idx)
      RG_ACT:  rd_val = {{(BYTE_W-1){1'b0}}, en_q};
      RG_B0H:  rd_val = b0_q[BASE_W-1:BYTE_W];
      RG_B0L:  rd_val = b0_q[BYTE_W-1:0];
      RG_B1H:  rd_val = b1_q[BASE_W-1:BYTE_W];
      RG_B1L:  rd_val = b1_q[BYTE_W-1:0];
      RG_IRQ:  rd_val = irq_q;
      default: rd_val = '0;
    endcase
  end

  assign rd_data = sel ? rd_val : '0;
  assign en      = en_q;
  assign base0   = b0_q;
  assign base1   = b1_q;
  assign irq     = irq_q;

  // A bank that is not addressed by a write keeps every setting
  assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel) |=> ($stable(en) && $stable(base0) && $stable(base1) && $stable(irq)));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                      ADDR_W     = 16,
  parameter int                      NUM_DEV    = 7,
  parameter logic [NUM_DEV*8-1:0]    DEV_LDNS   = {8'h0A, 8'h07, 8'h06, 8'h05, 8'h04, 8'h01, 8'h00},
  parameter logic [ADDR_W-1:0]       PORT_LO    = 16'h002E,
  parameter logic [ADDR_W-1:0]       PORT_HI    = 16'h004E,
  parameter logic [7:0]              KEY_END_LO = 8'h55,
  parameter logic [7:0]              KEY_END_HI = 8'hAA
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strap_alt,
  input  logic [ADDR_W-1:0]            io_addr,
  input  logic                         io_wr,
  input  logic                         io_rd,
  input  logic [BYTE_W-1:0]            io_wdata,
  output logic [BYTE_W-1:0]            io_rdata,
  output logic [NUM_DEV-1:0]           dev_en,
  output logic [NUM_DEV*2*BYTE_W-1:0]  dev_base0,
  output logic [NUM_DEV*2*BYTE_W-1:0]  dev_base1,
  output logic [NUM_DEV*BYTE_W-1:0]    dev_irq,
  output logic                         clk_sel_24m
);

  localparam int BASE_W = 2 * BYTE_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic [ADDR_W-1:0] addr_idx, addr_dat;
  logic [BYTE_W-1:0] key_last;
  logic              hit_idx, hit_dat;
  logic              unlocked;
  logic              key_wr, idx_we, dat_we, cfg_exit;

  assign addr_idx = strap_alt ? PORT_HI : PORT_LO;
  assign addr_dat = addr_idx + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign key_last = strap_alt ? KEY_END_HI : KEY_END_LO;
  assign hit_idx  = (io_addr == addr_idx);
  assign hit_dat  = (io_addr == addr_dat);

  logic [BYTE_W-1:0] idx_q, idx_d, ldn_q, ldn_d;
  logic              clk_q, clk_d;

  assign key_wr   = io_wr & hit_idx & ~unlocked;
  assign idx_we   = io_wr & hit_idx & unlocked;
  assign dat_we   = io_wr & hit_dat & unlocked;
  assign cfg_exit = dat_we & (idx_q == RG_CTRL) & (io_wdata == EXIT_CODE);

  sio_key_unlock u_key (
    .clk       (clk),
    .rst_n     (rst_int),
    .key_wr    (key_wr),
    .key_byte  (io_wdata),
    .last_byte (key_last),
    .relock    (cfg_exit),
    .unlocked  (unlocked)
  );

  // Global registers: next state
  always_comb begin
    idx_d = idx_we ? io_wdata : idx_q;
    ldn_d = ldn_q;
    clk_d = clk_q;
    if (dat_we && idx_q == RG_LDN) ldn_d = io_wdata;
    if (dat_we && idx_q == RG_CLK) clk_d = io_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      idx_q <= '0;
      ldn_q <= '0;
      clk_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      ldn_q <= ldn_d;
      clk_q <= clk_d;
    end
  end

  // Device banks
  logic [NUM_DEV-1:0]        bank_sel;
  logic [NUM_DEV*BYTE_W-1:0] bank_rd;
  logic                      bank_we;
  assign bank_we = dat_we & is_dev_reg(idx_q);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    localparam logic [BYTE_W-1:0] MY_LDN = DEV_LDNS[g*BYTE_W +: BYTE_W];
    assign bank_sel[g] = (ldn_q == MY_LDN);
    sio_ldev_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_int),
      .sel     (bank_sel[g]),
      .wr_en   (bank_we),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .en      (dev_en[g]),
      .base0   (dev_base0[g*BASE_W +: BASE_W]),
      .base1   (dev_base1[g*BASE_W +: BASE_W]),
      .irq     (dev_irq[g*BYTE_W +: BYTE_W]),
      .rd_data (bank_rd[g*BYTE_W +: BYTE_W])
    );
  end

  logic [BYTE_W-1:0] bank_any;
  always_comb begin
    bank_any = '0;
    for (int i = 0; i < NUM_DEV; i++) bank_any = bank_any | bank_rd[i*BYTE_W +: BYTE_W];
  end

  // Readback
  logic [BYTE_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit_idx || hit_dat) begin
      if (!unlocked)    rd_val = 8'hFF;
      else if (hit_idx) rd_val = idx_q;
      else if (is_dev_reg(idx_q)) rd_val = (|bank_sel) ? bank_any : 8'hFF;
      else if (idx_q == RG_LDN)   rd_val = ldn_q;
      else if (idx_q == RG_CLK)   rd_val = {{(BYTE_W-1){1'b0}}, clk_q};
    end
  end

  assign io_rdata    = io_rd ? rd_val : '0;
  assign clk_sel_24m = clk_q;

  assert_relock_R5: assert property (@(posedge clk) disable iff (!rst_int)
    cfg_exit |=> !unlocked);

  assert_locked_frozen_R4: assert property (@(posedge clk) disable iff (!rst_int)
    !unlocked |=> ($stable(dev_en) && $stable(dev_base0) && $stable(dev_base1) &&
                   $stable(dev_irq) && $stable(clk_sel_24m)));

  assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_int)
    (io_rd && hit_dat && !unlocked) |-> (io_rdata == 8'hFF));

  assert_clk_sel_write_R10: assert property (@(posedge clk) disable iff (!rst_int)
    (clk_sel_24m != $past(clk_sel_24m)) |-> $past(dat_we && idx_q == RG_CLK));

endmodule

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         strap_alt;
  logic [15:0]  io_addr;
  logic         io_wr, io_rd;
  logic [7:0]   io_wdata, io_rdata;
  logic [6:0]   dev_en;
  logic [111:0] dev_base0, dev_base1;
  logic [55:0]  dev_irq;
  logic         clk_sel_24m;

  always #2.5 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .dev_en(dev_en), .dev_base0(dev_base0), .dev_base1(dev_base1),
    .dev_irq(dev_irq), .clk_sel_24m(clk_sel_24m)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench model of the register state
  bit        m_locked;
  int        m_ks;
  bit [7:0]  m_idx, m_ldn;
  bit        m_clk;
  bit        m_en  [7];
  bit [15:0] m_b0  [7];
  bit [15:0] m_b1  [7];
  bit [7:0]  m_irq [7];

  function automatic bit [15:0] port_base();
    return strap_alt ? 16'h004E : 16'h002E;
  endfunction

  function automatic int slot_of(bit [7:0] l);
    case (l)
      8'h00: return 0;  8'h01: return 1;  8'h04: return 2;  8'h05: return 3;
      8'h06: return 4;  8'h07: return 5;  8'h0A: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic bit dev_reg(bit [7:0] r);
    return r == 8'h30 || r == 8'h60 || r == 8'h61 || r == 8'h62 || r == 8'h63 || r == 8'h70;
  endfunction

  function automatic int key_step(int ks, bit [7:0] d);
    int rs = (d == 8'h87) ? 1 : 0;
    case (ks)
      0: return rs;
      1: return (d == 8'h01) ? 2 : rs;
      2: return (d == 8'h55) ? 3 : rs;
      3: return (d == (strap_alt ? 8'hAA : 8'h55)) ? 4 : rs;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_locked = 1; m_ks = 0; m_idx = 0; m_ldn = 0; m_clk = 0;
    for (int i = 0; i < 7; i++) begin
      m_en[i] = 0; m_b0[i] = 0; m_b1[i] = 0; m_irq[i] = 0;
    end
  endtask

  task automatic model_write(bit [15:0] a, bit [7:0] d);
    int s;
    if (a == port_base()) begin
      if (m_locked) begin
        m_ks = key_step(m_ks, d);
        if (m_ks == 4) begin m_locked = 0; m_ks = 0; end
      end else m_idx = d;
    end else if (a == port_base() + 16'd1 && !m_locked) begin
      s = slot_of(m_ldn);
      if (m_idx == 8'h02 && d == 8'h02) m_locked = 1;
      else if (m_idx == 8'h07) m_ldn = d;
      else if (m_idx == 8'h23) m_clk = d[0];
      else if (dev_reg(m_idx) && s >= 0) begin
        case (m_idx)
          8'h30: m_en[s] = d[0];
          8'h60: m_b0[s][15:8] = d;
          8'h61: m_b0[s][7:0] = d;
          8'h62: m_b1[s][15:8] = d;
          8'h63: m_b1[s][7:0] = d;
          default: m_irq[s] = d;
        endcase
      end
    end
  endtask

  function automatic bit [7:0] model_read(bit [15:0] a);
    int s = slot_of(m_ldn);
    if (a != port_base() && a != port_base() + 16'd1) return 8'h00;
    if (m_locked) return 8'hFF;
    if (a == port_base()) return m_idx;
    if (dev_reg(m_idx)) begin
      if (s < 0) return 8'hFF;
      case (m_idx)
        8'h30: return {7'b0, m_en[s]};
        8'h60: return m_b0[s][15:8];
        8'h61: return m_b0[s][7:0];
        8'h62: return m_b1[s][15:8];
        8'h63: return m_b1[s][7:0];
        default: return m_irq[s];
      endcase
    end
    if (m_idx == 8'h07) return m_ldn;
    if (m_idx == 8'h23) return {7'b0, m_clk};
    return 8'h00;
  endfunction

  function automatic string read_tag(bit [15:0] a);
    if (a != port_base() && a != port_base() + 16'd1) return "R11";
    if (m_locked) return (a == port_base()) ? "R2" : "R4";
    if (a == port_base()) return "R11";
    if (dev_reg(m_idx)) return (slot_of(m_ldn) < 0) ? "R9" : (m_idx == 8'h30 ? "R7" : "R8");
    if (m_idx == 8'h07) return "R6";
    if (m_idx == 8'h23) return "R10";
    if (m_idx == 8'h02) return "R5";
    return "R11";
  endfunction

  task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_outputs(string tag);
    logic [6:0]   e_en;
    logic [111:0] e_b0, e_b1;
    logic [55:0]  e_irq;
    for (int i = 0; i < 7; i++) begin
      e_en[i] = m_en[i];
      e_b0[i*16 +: 16] = m_b0[i];
      e_b1[i*16 +: 16] = m_b1[i];
      e_irq[i*8 +: 8] = m_irq[i];
    end
    check(tag, "dev_en", {121'b0, dev_en}, {121'b0, e_en});
    check(tag, "dev_base0", {16'b0, dev_base0}, {16'b0, e_b0});
    check(tag, "dev_base1", {16'b0, dev_base1}, {16'b0, e_b1});
    check(tag, "dev_irq", {72'b0, dev_irq}, {72'b0, e_irq});
    check(tag, "clk_sel_24m", {127'b0, clk_sel_24m}, {127'b0, m_clk});
  endtask

  task automatic wr(bit [15:0] a, bit [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(bit [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    check(read_tag(a), "io_rdata", {120'b0, io_rdata}, {120'b0, model_read(a)});
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic key(bit [7:0] last);
    wr(port_base(), 8'h87); wr(port_base(), 8'h01);
    wr(port_base(), 8'h55); wr(port_base(), last);
  endtask

  task automatic do_reset(bit s);
    rst_n = 1'b0; strap_alt = s;
    io_addr = 0; io_wr = 0; io_rd = 0; io_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  function automatic bit [7:0] pick_idx();
    case ($urandom % 10)
      0: return 8'h02;  1: return 8'h07;  2: return 8'h23;  3: return 8'h30;
      4: return 8'h60;  5: return 8'h61;  6: return 8'h62;  7: return 8'h63;
      8: return 8'h70;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic random_ops(int n);
    bit [15:0] b;
    bit [7:0]  d;
    bit [7:0]  k [4];
    for (int i = 0; i < n; i++) begin
      b = port_base();
      case ($urandom % 16)
        0, 1: begin
          k[0] = 8'h87; k[1] = 8'h01; k[2] = 8'h55; k[3] = strap_alt ? 8'hAA : 8'h55;
          if ($urandom % 4 == 0) k[$urandom % 4] = 8'($urandom);
          for (int j = 0; j < 4; j++) wr(b, k[j]);
          rd(b);
        end
        2, 3, 4: wr(b, pick_idx());
        5, 6, 7, 8: begin
          if (m_idx == 8'h07) d = 8'($urandom % 12);
          else if (m_idx == 8'h02) d = ($urandom % 4 == 0) ? 8'h02 : 8'($urandom);
          else d = 8'($urandom);
          wr(b + 16'd1, d);
          chk_outputs(m_locked ? "R4" : "R8");
        end
        9, 10, 11: rd(b + 16'd1);
        12: rd(b);
        13: begin
          wr(b ^ 16'h0060, 8'($urandom));
          wr((b ^ 16'h0060) + 16'd1, 8'($urandom));
          chk_outputs("R2");
        end
        14: rd(16'($urandom));
        default: chk_outputs("R8");
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    // R1: reset state
    chk_outputs("R1");
    rd(16'h002E); rd(16'h002F);
    // R4: data writes while locked
    wr(16'h002F, 8'h5A);
    chk_outputs("R4");
    rd(16'h002F);
    // R2: wrong last byte for this strap keeps the lock
    key(8'hAA);
    rd(16'h002E);
    // R3: 0x87 inside the sequence restarts a new attempt
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h87);
    wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
    rd(16'h002E);
    // R9: unimplemented device
    wr(16'h002E, 8'h07); wr(16'h002F, 8'h02);
    wr(16'h002E, 8'h30); rd(16'h002F);
    wr(16'h002F, 8'h01); chk_outputs("R9"); rd(16'h002F);
    // R6/R7/R8: last slot
    wr(16'h002E, 8'h07); wr(16'h002F, 8'h0A); rd(16'h002F);
    wr(16'h002E, 8'h30); wr(16'h002F, 8'hFF); rd(16'h002F);
    wr(16'h002E, 8'h60); wr(16'h002F, 8'h12);
    wr(16'h002E, 8'h61); wr(16'h002F, 8'h34);
    wr(16'h002E, 8'h63); wr(16'h002F, 8'hC8);
    wr(16'h002E, 8'h70); wr(16'h002F, 8'h05); rd(16'h002F);
    chk_outputs("R8");
    // R10: clock select
    wr(16'h002E, 8'h23); wr(16'h002F, 8'h01); rd(16'h002F);
    chk_outputs("R10");
    // R5: exit code handling
    wr(16'h002E, 8'h02); wr(16'h002F, 8'h03); rd(16'h002F); rd(16'h002E);
    wr(16'h002F, 8'h02); rd(16'h002E); rd(16'h002F);
    wr(16'h002E, 8'h23); wr(16'h002F, 8'h00);
    chk_outputs("R4");
    random_ops(1500);

    do_reset(1'b1);
    chk_outputs("R1");
    // R2: strap high needs 0xAA and answers at 0x4E only
    key(8'h55); rd(16'h004E);
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'hAA);
    rd(16'h004E);
    key(8'hAA); rd(16'h004E);
    wr(16'h004E, 8'h07); wr(16'h004F, 8'h04); rd(16'h004F);
    wr(16'h004E, 8'h62); wr(16'h004F, 8'hA5); rd(16'h004F);
    wr(16'h002E, 8'h63); rd(16'h002F);
    chk_outputs("R8");
    random_ops(1500);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule